// File: doc/BRIEF.md
# Peripheral Interrupt Priority Controller

This block collects interrupt requests from five on-chip peripheral sources: two timers, a serial bus controller, a UART and an ADC. Each source has a one-bit pending flag and a three-bit priority level. Both live in four byte-wide control registers on a small register bus. Software can read and write these registers as single bytes or as 16-bit words, and every access is acknowledged one cycle later without wait states.

The block presents the highest level among the pending sources to the processor as a three-bit request level. A level of zero masks its source. When the processor runs an acknowledge cycle, it tags the cycle with the level it is serving. The block then answers in the same cycle with an autovector number in the range 57 to 63 and clears the pending flag of the source it chose. When several pending sources share the acknowledged level, a fixed order decides which one is served.

Top module: `pic_top`

## Requirements
- R1: After reset every pending flag and every level reads 0, `irq_lvl_o` is 0 and `iack_hit_o` is 0.
- R2: A one-cycle pulse on `req_i[k]` sets the pending flag of source k at the next clock edge. Source bits are: 0 timer A, 1 timer B, 2 serial bus, 3 UART, 4 ADC. Each source occupies a nibble with bit 3 as the pending flag and bits 2:0 as the level. Timer A uses register 0 bits 3:0 and timer B uses register 0 bits 7:4. The serial bus, UART and ADC use the low nibble of registers 1, 2 and 3. The upper nibbles of registers 1 to 3 always read 0 and ignore writes.
- R3: A byte access on address 0 to 3 reads or writes `bus_rdata_o[7:0]`/`bus_wdata_i[7:0]`, with the read's upper byte 0. A word access ignores address bit 0. It places the even register on bits 15:8 and the odd register on bits 7:0. `bus_ack_o` is high, and read data is valid, in the cycle after each select.
- R4: Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged. The level bits take the written value.
- R5: A request pulse in the same cycle as a software clear or an acknowledge clear of that source leaves the flag set.
- R6: `irq_lvl_o` equals the largest level among the sources that are pending with a non-zero level, or 0 if there is none. A level of 0 masks its source.
- R7: While `iack_i` is high with a non-zero `iack_lvl_i` that matches the level of some pending source, `iack_hit_o` is 1 and `iack_vec_o` is 56 plus `iack_lvl_i` (57 for level 1, 63 for level 7) in the same cycle.
- R8: Among matching sources, the lowest source bit wins (timer A, timer B, serial bus, UART, ADC). Only that source's flag is cleared at the clock edge.
- R9: An acknowledge cycle never changes any level.
- R10: An acknowledge with no matching pending source, or with level 0, gives `iack_hit_o` 0 and `iack_vec_o` 0, and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Per-source request pulses |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr_i | input | 2 | Register byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid with the acknowledge |
| bus_ack_o | output | 1 | Access acknowledge, one cycle after select |
| irq_lvl_o | output | 3 | Highest active request level |
| iack_i | input | 1 | Processor acknowledge cycle |
| iack_lvl_i | input | 3 | Level being acknowledged |
| iack_hit_o | output | 1 | A source answered the acknowledge |
| iack_vec_o | output | 8 | Autovector number, 0 when no hit |

## Verification
A corrupted pending flag or level shows on `irq_lvl_o` in the cycle after it happens, and on the next register read one cycle after the select. A wrong tie-break or a wrong clear stays hidden until the next acknowledge at the same level. At that point the wrong source's flag persists in read-back, or the request level fails to drop. Same-cycle collisions of a request with a software clear or an acknowledge clear are driven on purpose, because a lost set in that case would drop an interrupt without any other trace.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned NUM_REG  = 4;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned REG_AW   = $clog2(NUM_REG);

  typedef struct packed {
    logic             pend;
    logic [LVL_W-1:0] lvl;
  } slot_t;

  // register that holds a source
  function automatic int unsigned src_reg(int unsigned i);
    return (i < 2) ? 0 : i - 1;
  endfunction

  // nibble (0 low, 1 high) inside that register
  function automatic int unsigned src_nib(int unsigned i);
    return (i == 1) ? 1 : 0;
  endfunction
endpackage

// File: rtl/pic_slot.sv
module pic_slot
  import pic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  wr_en_i,
  input  slot_t wr_nib_i,
  input  logic  ack_clr_i,
  output slot_t slot_o
);
  slot_t q, d;
  logic  en;

  always_comb begin
    d  = q;
    en = req_i | wr_en_i | ack_clr_i;
    if (wr_en_i) begin
      d.lvl = wr_nib_i.lvl;
      if (!wr_nib_i.pend) d.pend = 1'b0;
    end
    if (ack_clr_i) d.pend = 1'b0;
    if (req_i)     d.pend = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (en)  q <= d;
  end

  assign slot_o = q;
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic                bus_word_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [15:0]         bus_wdata_i,
  output logic [15:0]         bus_rdata_o,
  output logic                bus_ack_o,
  input  slot_t [NUM_SRC-1:0] slots_i,
  output logic [NUM_SRC-1:0]  wr_en_o,
  output slot_t [NUM_SRC-1:0] wr_nib_o
);
  logic [NUM_REG-1:0] be;
  logic [7:0]         wbyte [NUM_REG];
  logic [7:0]         rb    [NUM_REG];
  logic [15:0]        rdata_d, rdata_q;
  logic               ack_q, rd_en;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam logic [REG_AW-1:0] RA = REG_AW'(r);
    assign be[r] = bus_sel_i & bus_wr_i &
                   (bus_word_i ? (bus_addr_i[REG_AW-1:1] == RA[REG_AW-1:1])
                               : (bus_addr_i == RA));
    assign wbyte[r] = (bus_word_i && !RA[0]) ? bus_wdata_i[15:8] : bus_wdata_i[7:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned R = src_reg(i);
    localparam int unsigned N = src_nib(i);
    assign wr_en_o[i]  = be[R];
    assign wr_nib_o[i] = (N == 1) ? wbyte[R][7:4] : wbyte[R][3:0];
  end

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) rb[r] = 8'h00;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_nib(i) == 1) rb[REG_AW'(src_reg(i))][7:4] = slots_i[i];
      else                 rb[REG_AW'(src_reg(i))][3:0] = slots_i[i];
    end
    if (bus_word_i)
      rdata_d = {rb[{bus_addr_i[REG_AW-1:1], 1'b0}], rb[{bus_addr_i[REG_AW-1:1], 1'b1}]};
    else
      rdata_d = {8'h00, rb[bus_addr_i]};
    rd_en = bus_sel_i & ~bus_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= bus_sel_i;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_ack_o   = ack_q;
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int unsigned VEC_BASE = 56
) (
  input  slot_t [NUM_SRC-1:0] slots_i,
  input  logic                iack_i,
  input  logic [LVL_W-1:0]    iack_lvl_i,
  output logic [LVL_W-1:0]    irq_lvl_o,
  output logic [NUM_SRC-1:0]  grant_o,
  output logic                hit_o,
  output logic [VEC_W-1:0]    vec_o
);
  always_comb begin
    logic found;
    irq_lvl_o = '0;
    grant_o   = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (slots_i[i].pend && slots_i[i].lvl > irq_lvl_o) irq_lvl_o = slots_i[i].lvl;
      if (!found && iack_i && slots_i[i].pend && slots_i[i].lvl != '0 &&
          slots_i[i].lvl == iack_lvl_i) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    hit_o = found;
    vec_o = found ? VEC_W'(VEC_BASE) + VEC_W'(iack_lvl_i) : '0;
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int unsigned VEC_BASE = 56
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  req_i,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic                bus_word_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [15:0]         bus_wdata_i,
  output logic [15:0]         bus_rdata_o,
  output logic                bus_ack_o,
  output logic [LVL_W-1:0]    irq_lvl_o,
  input  logic                iack_i,
  input  logic [LVL_W-1:0]    iack_lvl_i,
  output logic                iack_hit_o,
  output logic [VEC_W-1:0]    iack_vec_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_n;
  slot_t [NUM_SRC-1:0] slots, wr_nib;
  logic  [NUM_SRC-1:0] wr_en, grant;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    pic_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .req_i     (req_i[i]),
      .wr_en_i   (wr_en[i]),
      .wr_nib_i  (wr_nib[i]),
      .ack_clr_i (grant[i]),
      .slot_o    (slots[i])
    );
  end

  pic_regif u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_word_i  (bus_word_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_ack_o   (bus_ack_o),
    .slots_i     (slots),
    .wr_en_o     (wr_en),
    .wr_nib_o    (wr_nib)
  );

  pic_arbiter #(.VEC_BASE(VEC_BASE)) u_arb (
    .slots_i    (slots),
    .iack_i     (iack_i),
    .iack_lvl_i (iack_lvl_i),
    .irq_lvl_o  (irq_lvl_o),
    .grant_o    (grant),
    .hit_o      (iack_hit_o),
    .vec_o      (iack_vec_o)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int unsigned VEC_BASE = 56
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic [NUM_SRC-1:0]  req_i,
  input logic                bus_sel_i,
  input logic                bus_wr_i,
  input logic                bus_ack_o,
  input logic [LVL_W-1:0]    irq_lvl_o,
  input logic                iack_i,
  input logic [LVL_W-1:0]    iack_lvl_i,
  input logic                iack_hit_o,
  input logic [VEC_W-1:0]    iack_vec_o,
  input logic [NUM_SRC-1:0]  grant,
  input slot_t [NUM_SRC-1:0] slots
);
  logic [NUM_SRC-1:0]       pend;
  logic [NUM_SRC*LVL_W-1:0] lvls;
  logic                     lvl_seen;

  always_comb begin
    lvl_seen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      pend[i] = slots[i].pend;
      lvls[i*LVL_W +: LVL_W] = slots[i].lvl;
      if (slots[i].pend && slots[i].lvl == irq_lvl_o) lvl_seen = 1'b1;
    end
  end

  p_bus_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    bus_sel_i |=> bus_ack_o);

  p_req_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_i != '0) |=> ((pend & $past(req_i)) == $past(req_i)));

  p_irq_source_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_lvl_o != '0) |-> lvl_seen);

  p_vec_map_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    iack_hit_o |-> (iack_lvl_i != '0 && iack_vec_o == VEC_W'(VEC_BASE) + VEC_W'(iack_lvl_i)));

  p_one_winner_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(grant) && (iack_hit_o == (grant != '0)));

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    iack_hit_o |=> ((pend & $past(grant & ~req_i)) == '0));

  p_lvl_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(bus_sel_i && bus_wr_i) |=> $stable(lvls));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !iack_i |-> (!iack_hit_o && iack_vec_o == '0));
endmodule

bind pic_top pic_checker #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .bus_sel_i  (bus_sel_i),
  .bus_wr_i   (bus_wr_i),
  .bus_ack_o  (bus_ack_o),
  .irq_lvl_o  (irq_lvl_o),
  .iack_i     (iack_i),
  .iack_lvl_i (iack_lvl_i),
  .iack_hit_o (iack_hit_o),
  .iack_vec_o (iack_vec_o),
  .grant      (grant),
  .slots      (slots)
);

// File: tb/test_pic_top.sv
`timescale 1ns/100ps
module test_pic_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req;
  logic        sel, wr, word;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        ack;
  logic [2:0]  irq_lvl, ak_lvl;
  logic        ak, hit;
  logic [7:0]  vec;

  int checks = 0, fails = 0;
  bit done = 0;

  logic       pend_m [5];
  logic [2:0] lvl_m  [5];

  always #2.5 clk = ~clk;

  pic_top i_pic_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_word_i(word), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_ack_o(ack),
    .irq_lvl_o(irq_lvl), .iack_i(ak), .iack_lvl_i(ak_lvl),
    .iack_hit_o(hit), .iack_vec_o(vec)
  );

  function automatic int sreg(int i); return (i < 2) ? 0 : i - 1; endfunction
  function automatic int snib(int i); return (i == 1) ? 1 : 0;    endfunction

  function automatic logic [7:0] exp_byte(int r);
    logic [7:0] b = 8'h00;
    for (int i = 0; i < 5; i++)
      if (sreg(i) == r) begin
        if (snib(i) == 1) b[7:4] = {pend_m[i], lvl_m[i]};
        else              b[3:0] = {pend_m[i], lvl_m[i]};
      end
    return b;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] m = 3'd0;
    for (int i = 0; i < 5; i++) if (pend_m[i] && lvl_m[i] > m) m = lvl_m[i];
    return m;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_wbyte(int r, logic [7:0] b);
    for (int i = 0; i < 5; i++)
      if (sreg(i) == r) begin
        logic [3:0] n = (snib(i) == 1) ? b[7:4] : b[3:0];
        if (!n[3]) pend_m[i] = 1'b0;
        lvl_m[i] = n[2:0];
      end
  endtask

  task automatic bus_write(logic w, logic [1:0] a, logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; word = w; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
    if (w) begin m_wbyte({a[1], 1'b0}, d[15:8]); m_wbyte({a[1], 1'b1}, d[7:0]); end
    else   m_wbyte(a, d[7:0]);
  endtask

  task automatic bus_read(string tag, logic w, logic [1:0] a, logic [15:0] exp);
    @(negedge clk); sel = 1; wr = 0; word = w; addr = a;
    @(negedge clk); sel = 0;
    chk({tag, " ack"}, 16'(ack), 16'd1);
    chk(tag, rdata, exp);
  endtask

  task automatic check_regs(string tag);
    for (int r = 0; r < 4; r++) bus_read(tag, 1'b0, 2'(r), {8'h00, exp_byte(r)});
    chk({tag, " irq"}, 16'(irq_lvl), 16'(exp_irq()));
  endtask

  task automatic pulse(logic [4:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
    for (int i = 0; i < 5; i++) if (m[i]) pend_m[i] = 1'b1;
  endtask

  task automatic do_iack(string tag, logic [2:0] l);
    int w = -1;
    for (int i = 0; i < 5; i++)
      if (w < 0 && l != 0 && pend_m[i] && lvl_m[i] == l) w = i;
    @(negedge clk); ak = 1; ak_lvl = l;
    #1;
    chk({tag, " hit"}, 16'(hit), 16'(w >= 0));
    chk({tag, " vec"}, 16'(vec), (w >= 0) ? 16'(56 + l) : 16'd0);
    @(negedge clk); ak = 0;
    if (w >= 0) pend_m[w] = 1'b0;
    chk({tag, " irq"}, 16'(irq_lvl), 16'(exp_irq()));
  endtask

  task automatic t_reset;
    chk("R1 irq", 16'(irq_lvl), 16'd0);
    chk("R1 hit", 16'(hit), 16'd0);
    check_regs("R1 regs");
  endtask

  task automatic t_layout;
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      check_regs("R2 layout");
    end
    chk("R6 masked at level 0", 16'(irq_lvl), 16'd0);
    bus_write(0, 2'd1, 16'h00F8);   // upper nibble ignored
    check_regs("R2 upper nibble");
    for (int r = 0; r < 4; r++) bus_write(0, 2'(r), 16'h0000);
    check_regs("R4 clear all");
  endtask

  task automatic t_write;
    bus_write(0, 2'd0, 16'h009D);   // writing 1 to pend has no effect
    check_regs("R4 set ignored");
    pulse(5'b00001);
    check_regs("R4 pending");
    bus_write(0, 2'd0, 16'h0015);
    check_regs("R4 write zero clears");
  endtask

  task automatic t_word;
    bus_write(1, 2'd2, 16'h0604);
    bus_read("R3 word low pair", 1, 2'd0, {exp_byte(0), exp_byte(1)});
    bus_read("R3 word addr bit0 ignored", 1, 2'd3, {exp_byte(2), exp_byte(3)});
    check_regs("R3 byte view");
  endtask

  task automatic t_priority;
    bus_write(1, 2'd0, 16'h1503);   // t1=1 t0=5, sbus=3
    bus_write(1, 2'd2, 16'h0604);   // uart=6 adc=4
    pulse(5'b00101);
    chk("R6 max of t0/sbus", 16'(irq_lvl), 16'd5);
    pulse(5'b01000);
    chk("R6 uart higher", 16'(irq_lvl), 16'd6);
    bus_write(0, 2'd2, 16'h0008);   // uart level 0, keep pending
    chk("R6 level 0 masks", 16'(irq_lvl), 16'd5);
    check_regs("R6 regs");
  endtask

  task automatic t_ack;
    do_iack("R7 ack level 5", 3'd5);
    check_regs("R9 level kept after ack");
    do_iack("R7 ack level 3", 3'd3);
    check_regs("R8 only winner cleared");
  endtask

  task automatic t_tie;
    bus_write(0, 2'd0, 16'h0040);   // t1=4 t0=0
    bus_write(0, 2'd3, 16'h0004);
    pulse(5'b10010);
    chk("R8 tie irq", 16'(irq_lvl), 16'd4);
    do_iack("R8 tie first", 3'd4);
    check_regs("R8 adc still pending");
    do_iack("R8 tie second", 3'd4);
    check_regs("R8 both served");
  endtask

  task automatic t_bounds;
    do_iack("R10 no match", 3'd2);
    do_iack("R10 level zero", 3'd0);
    check_regs("R10 nothing cleared");
    bus_write(1, 2'd0, 16'h0701);   // t0=7, sbus=1
    pulse(5'b00101);
    do_iack("R7 level 7 vector 63", 3'd7);
    do_iack("R7 level 1 vector 57", 3'd1);
    check_regs("R9 bounds");
  endtask

  task automatic t_collision;
    pulse(5'b00001);
    @(negedge clk); req = 5'b00001; ak = 1; ak_lvl = 3'd7;
    #1 chk("R5 ack hit", 16'(hit), 16'd1);
    @(negedge clk); req = '0; ak = 0;
    check_regs("R5 set beats ack clear");
    @(negedge clk); req = 5'b00001; sel = 1; wr = 1; word = 0; addr = 2'd0;
    wdata = {8'h00, 1'b1, lvl_m[1], 4'h7};
    @(negedge clk); req = '0; sel = 0; wr = 0;
    check_regs("R5 set beats write clear");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin pend_m[i] = 0; lvl_m[i] = 0; end
    rst_n = 0; req = 0; sel = 0; wr = 0; word = 0; addr = 0; wdata = 0; ak = 0; ak_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_write();
    t_word();
    t_priority();
    t_ack();
    t_tie();
    t_bounds();
    t_collision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule